// File: doc/BRIEF.md
# Timer Counter with Shared Prescaler

This block is an 8-bit free-running counter with a single 8-bit power-of-two prescaler that is handed either to the counter or to a watchdog. The counter can step on instruction cycles (a cycle enable in the core clock domain) or on a chosen edge of an external pin. The watchdog steps on a base tick that comes from a slow oscillator outside the block. A 6-bit mode word, loaded by the core from its working register, picks the counter's source and pin edge, the owner of the prescaler, and the divide setting.

The counter can be read at any time and loaded by the core. It raises a one-cycle overflow pulse when it rolls over. The watchdog raises a one-cycle time-out pulse when its own counter rolls over. The core stops that from happening by pulsing a clear strobe often enough. Mode bit layout: bits 2:0 are the divide select `ps`, bit 3 is the owner (0 = counter, 1 = watchdog), bit 4 is the pin edge (0 = rising, 1 = falling), and bit 5 is the source (0 = cycle enable, 1 = pin).

Top module: `rtc_prescale_top`

## Requirements
- R1: After reset the counter reads 0x00, both pulse outputs are low, and the mode word is 0x3F (pin source, falling edge, prescaler on the watchdog, select 7).
- R2: With mode bit 3 = 0, the counter advances once per 2^(ps+1) source events (ratios 1:2 to 1:256).
- R3: With mode bit 3 = 1, the counter advances on every source event, and the watchdog advances once per 2^ps base ticks (1:1 to 1:128). With bit 3 = 0, the watchdog advances on every base tick.
- R4: With mode bit 5 = 0, the source event is each clock with `cyc_en_i` high, and the pin has no effect on the counter.
- R5: With mode bit 5 = 1, the pin passes through a two-flop synchronizer. The counter moves at the third rising clock edge after the pin changes: on a rising pin edge when bit 4 = 0, on a falling pin edge when bit 4 = 1. `cyc_en_i` then has no effect.
- R6: A counter write loads `cnt_wdata_i` at the next edge, with no increment in that cycle, and clears the prescaler.
- R7: The counter wraps from 0xFF to 0x00. `cnt_ovf_o` is high for exactly the one cycle in which the counter first reads 0x00.
- R8: The watchdog counter is WDT_W bits wide (256 steps by default). `wdt_timeout_o` is a one-cycle pulse in the cycle after the step that wraps it.
- R9: `wdt_clr_i` zeroes the watchdog counter and, when the prescaler belongs to the watchdog, also the prescaler. A clear suppresses a time-out in the same cycle.
- R10: A mode write clears the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_en_i | input | 1 | Instruction-cycle enable |
| ext_pin_i | input | 1 | External count pin, asynchronous |
| mode_we_i | input | 1 | Mode word write strobe |
| mode_wdata_i | input | 6 | Mode word from working register |
| cnt_we_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 8 | Counter write data |
| cnt_o | output | 8 | Counter value |
| cnt_ovf_o | output | 1 | Counter wrap pulse |
| wdt_clr_i | input | 1 | Watchdog clear strobe |
| wdt_tick_i | input | 1 | Watchdog base tick, one clock wide |
| wdt_timeout_o | output | 1 | Watchdog time-out pulse |

## Verification
Strobes, cycle-enable pulses and ticks take effect at the next rising edge. The counter value, the overflow pulse and the time-out pulse can therefore be seen one clock after the event that caused them. The one exception is a pin transition, which shows in the counter only after three edges. The bench drives inputs and samples outputs at falling edges. For the pin path it checks that the count is still unchanged two edges after a transition and has moved after the third. The watchdog checks follow the time-out flag after every single tick, so a pulse that arrives one tick too early or too late is caught.

// File: rtl/rtc_prescale_pkg.sv
package rtc_prescale_pkg;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned MODE_W = SEL_W + 3;

  typedef struct packed {
    logic             src_pin;   // 1: count pin transitions
    logic             fall_edge; // 1: count high-to-low
    logic             to_wdt;    // 1: prescaler owned by watchdog
    logic [SEL_W-1:0] ps;
  } mode_t;

  localparam mode_t MODE_RST = '{src_pin: 1'b1, fall_edge: 1'b1, to_wdt: 1'b1, ps: '1};
endpackage

// File: rtl/rtc_pin_edge.sv
module rtc_pin_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= pin_i;
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[i] <= 1'b0;
      else         sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign edge_o = fall_sel_i ? (prev_q & ~sync_q[SYNC_STAGES-1])
                             : (~prev_q & sync_q[SYNC_STAGES-1]);
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned PS_W = 8,
  localparam int unsigned K_W = $clog2(PS_W + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           evt_i,
  input  logic           clr_i,
  input  logic [K_W-1:0] shift_i, // divide by 2^shift_i, 0..PS_W
  output logic           evt_o
);
  logic [PS_W-1:0] pre_q;
  logic [PS_W-1:0] mask;

  // shift_i == PS_W wraps the one to zero, giving an all-ones mask
  assign mask  = (PS_W'(1) << shift_i) - PS_W'(1);
  assign evt_o = evt_i & ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pre_q <= '0;
    else if (clr_i) pre_q <= '0;
    else if (evt_i) pre_q <= pre_q + PS_W'(1);
  end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else if (we_i) begin
      cnt_o <= wdata_i;
      ovf_o <= 1'b0;
    end else if (evt_i) begin
      cnt_o <= cnt_o + CNT_W'(1);
      ovf_o <= &cnt_o;
    end else begin
      ovf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_wdt.sv
module rtc_wdt #(
  parameter int unsigned WDT_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  output logic timeout_o
);
  logic [WDT_W-1:0] wdt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdt_q     <= '0;
      timeout_o <= 1'b0;
    end else if (clr_i) begin
      wdt_q     <= '0;
      timeout_o <= 1'b0;
    end else if (evt_i) begin
      wdt_q     <= wdt_q + WDT_W'(1);
      timeout_o <= &wdt_q;
    end else begin
      timeout_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_prescale_top.sv
module rtc_prescale_top
  import rtc_prescale_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned WDT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_en_i,
  input  logic              ext_pin_i,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  input  logic              cnt_we_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              cnt_ovf_o,
  input  logic              wdt_clr_i,
  input  logic              wdt_tick_i,
  output logic              wdt_timeout_o
);
  localparam int unsigned PS_W = 1 << SEL_W;
  localparam int unsigned K_W  = $clog2(PS_W + 1);

  mode_t          mode_q;
  logic           pin_evt, src_evt;
  logic           pre_in, pre_out, pre_clr;
  logic [K_W-1:0] shift;
  logic           cnt_evt, wdt_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= MODE_RST;
    else if (mode_we_i) mode_q <= mode_t'(mode_wdata_i);
  end

  rtc_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (ext_pin_i),
    .fall_sel_i (mode_q.fall_edge),
    .edge_o     (pin_evt)
  );

  assign src_evt = mode_q.src_pin ? pin_evt : cyc_en_i;

  // Counter-owned table sits one power of two above the watchdog one
  assign shift   = mode_q.to_wdt ? K_W'(mode_q.ps) : K_W'(mode_q.ps) + K_W'(1);
  assign pre_in  = mode_q.to_wdt ? wdt_tick_i : src_evt;
  assign pre_clr = cnt_we_i | mode_we_i | (wdt_clr_i & mode_q.to_wdt);

  rtc_prescaler #(.PS_W(PS_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (pre_in),
    .clr_i   (pre_clr),
    .shift_i (shift),
    .evt_o   (pre_out)
  );

  assign cnt_evt = mode_q.to_wdt ? src_evt : pre_out;
  assign wdt_evt = mode_q.to_wdt ? pre_out : wdt_tick_i;

  rtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (cnt_evt),
    .we_i    (cnt_we_i),
    .wdata_i (cnt_wdata_i),
    .cnt_o   (cnt_o),
    .ovf_o   (cnt_ovf_o)
  );

  rtc_wdt #(.WDT_W(WDT_W)) u_wdt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (wdt_evt),
    .clr_i     (wdt_clr_i),
    .timeout_o (wdt_timeout_o)
  );
endmodule

// File: rtl/rtc_prescale_chk.sv
module rtc_prescale_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cyc_en_i,
  input logic             mode_src_pin,
  input logic             cnt_we_i,
  input logic [CNT_W-1:0] cnt_wdata_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             cnt_ovf_o,
  input logic             wdt_clr_i,
  input logic             wdt_timeout_o
);
  // R6
  cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> cnt_o == $past(cnt_wdata_i));

  // R7
  ovf_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_ovf_o |-> cnt_o == '0);

  // R7
  ovf_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_ovf_o |=> !cnt_ovf_o);

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_we_i |=> (cnt_o == $past(cnt_o)) || (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));

  // R4
  cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_we_i && !mode_src_pin && !cyc_en_i) |=> $stable(cnt_o));

  // R8
  timeout_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_timeout_o |=> !wdt_timeout_o);

  // R9
  clr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_i |=> !wdt_timeout_o);
endmodule

bind rtc_prescale_top rtc_prescale_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cyc_en_i      (cyc_en_i),
  .mode_src_pin  (mode_q.src_pin),
  .cnt_we_i      (cnt_we_i),
  .cnt_wdata_i   (cnt_wdata_i),
  .cnt_o         (cnt_o),
  .cnt_ovf_o     (cnt_ovf_o),
  .wdt_clr_i     (wdt_clr_i),
  .wdt_timeout_o (wdt_timeout_o)
);

// File: tb/rtc_prescale_top_tb_top.sv
module rtc_prescale_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 50000;
  localparam int WDT_STEPS  = 256;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cyc_en_i = 1'b0;
  logic       ext_pin_i = 1'b0;
  logic       mode_we_i = 1'b0;
  logic [5:0] mode_wdata_i = '0;
  logic       cnt_we_i = 1'b0;
  logic [7:0] cnt_wdata_i = '0;
  logic [7:0] cnt_o;
  logic       cnt_ovf_o;
  logic       wdt_clr_i = 1'b0;
  logic       wdt_tick_i = 1'b0;
  logic       wdt_timeout_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rtc_prescale_top dut_i (.*);

  // {mode[5:0] in low bits of byte, cycles, expected count}
  localparam logic [31:0] VEC [6] = '{
    {8'h00, 16'd10,  8'd5},   // ratio 1:2
    {8'h02, 16'd40,  8'd5},   // ratio 1:8
    {8'h07, 16'd600, 8'd2},   // ratio 1:256
    {8'h01, 16'd13,  8'd3},   // ratio 1:4
    {8'h08, 16'd7,   8'd7},   // prescaler on watchdog: 1:1
    {8'h0F, 16'd9,   8'd9}    // watchdog-owned, select ignored by counter
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [5:0] v);
    mode_wdata_i = v; mode_we_i = 1'b1;
    @(negedge clk_i); mode_we_i = 1'b0;
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    cnt_wdata_i = v; cnt_we_i = 1'b1;
    @(negedge clk_i); cnt_we_i = 1'b0;
  endtask

  task automatic run_cyc(input int n);
    cyc_en_i = 1'b1;
    repeat (n) @(negedge clk_i);
    cyc_en_i = 1'b0;
  endtask

  task automatic clr_wdt();
    wdt_clr_i = 1'b1;
    @(negedge clk_i); wdt_clr_i = 1'b0;
  endtask

  task automatic ticks(input int n, output bit seen);
    seen = 1'b0;
    wdt_tick_i = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (wdt_timeout_o) seen = 1'b1;
    end
    wdt_tick_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (MAX_CYCLES) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL hang R8 act=%0d exp=%0d", MAX_CYCLES, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    bit seen;
    logic [7:0] base;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state; default mode has pin source, so cycle enable must not count
    chk(cnt_o == 8'h00, "R1 cnt reset", cnt_o, 0);
    chk(!cnt_ovf_o && !wdt_timeout_o, "R1 pulses low", {cnt_ovf_o, wdt_timeout_o}, 0);
    run_cyc(5);
    chk(cnt_o == 8'h00, "R1 reset mode pin source", cnt_o, 0);

    // R2/R3 ratio table walk
    foreach (VEC[i]) begin
      wr_mode(VEC[i][29:24]);
      wr_cnt(8'h00);
      run_cyc(int'(VEC[i][23:8]));
      chk(cnt_o == VEC[i][7:0], $sformatf("R2/R3 vec%0d", i), cnt_o, VEC[i][7:0]);
    end

    // R4 pin ignored with internal source
    wr_mode(6'h08); wr_cnt(8'h40);
    ext_pin_i = 1'b1; repeat (4) @(negedge clk_i);
    ext_pin_i = 1'b0; repeat (4) @(negedge clk_i);
    chk(cnt_o == 8'h40, "R4 pin ignored", cnt_o, 8'h40);

    // R7 wrap and overflow pulse
    wr_cnt(8'hFE);
    run_cyc(1);
    chk(cnt_o == 8'hFF && !cnt_ovf_o, "R7 pre-wrap", cnt_o, 8'hFF);
    run_cyc(1);
    chk(cnt_o == 8'h00, "R7 wrap value", cnt_o, 0);
    chk(cnt_ovf_o, "R7 ovf high", cnt_ovf_o, 1);
    @(negedge clk_i);
    chk(!cnt_ovf_o, "R7 ovf one cycle", cnt_ovf_o, 0);

    // R5 rising edge, latency, polarity, cycle enable ignored
    wr_mode(6'h28); wr_cnt(8'h10);
    ext_pin_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(cnt_o == 8'h10, "R5 not before third edge", cnt_o, 8'h10);
    @(negedge clk_i);
    chk(cnt_o == 8'h11, "R5 rise counted", cnt_o, 8'h11);
    ext_pin_i = 1'b0; repeat (4) @(negedge clk_i);
    chk(cnt_o == 8'h11, "R5 fall ignored in rise mode", cnt_o, 8'h11);
    run_cyc(6);
    chk(cnt_o == 8'h11, "R5 cyc_en ignored", cnt_o, 8'h11);
    wr_mode(6'h38);
    ext_pin_i = 1'b1; repeat (4) @(negedge clk_i);
    chk(cnt_o == 8'h11, "R5 rise ignored in fall mode", cnt_o, 8'h11);
    ext_pin_i = 1'b0; repeat (4) @(negedge clk_i);
    chk(cnt_o == 8'h12, "R5 fall counted", cnt_o, 8'h12);

    // R6 write clears prescaler (1:2)
    wr_mode(6'h00); wr_cnt(8'h00);
    run_cyc(1);
    wr_cnt(8'h00);
    run_cyc(1);
    chk(cnt_o == 8'h00, "R6 prescaler cleared by write", cnt_o, 0);
    run_cyc(1);
    chk(cnt_o == 8'h01, "R6 count after clear", cnt_o, 1);

    // R6 no increment in write cycle
    cyc_en_i = 1'b1; cnt_wdata_i = 8'h80; cnt_we_i = 1'b1;
    @(negedge clk_i); cnt_we_i = 1'b0; cyc_en_i = 1'b0;
    chk(cnt_o == 8'h80, "R6 load wins", cnt_o, 8'h80);

    // R10 mode write clears prescaler
    wr_cnt(8'h00);
    run_cyc(1);
    wr_mode(6'h00);
    run_cyc(1);
    chk(cnt_o == 8'h00, "R10 prescaler cleared by mode write", cnt_o, 0);
    run_cyc(1);
    chk(cnt_o == 8'h01, "R10 count after clear", cnt_o, 1);

    // R8 watchdog direct when prescaler on counter
    base = cnt_o;
    clr_wdt();
    ticks(WDT_STEPS - 1, seen);
    chk(!seen, "R8 no early timeout", seen, 0);
    ticks(1, seen);
    chk(seen, "R8 timeout on wrap", seen, 1);
    @(negedge clk_i);
    chk(!wdt_timeout_o, "R8 timeout one cycle", wdt_timeout_o, 0);
    chk(cnt_o == base, "R3 counter untouched by ticks", cnt_o, base);

    // R9 clear restarts watchdog
    ticks(200, seen);
    clr_wdt();
    ticks(WDT_STEPS - 1, seen);
    chk(!seen, "R9 clear restarts", seen, 0);
    ticks(1, seen);
    chk(seen, "R9 timeout after restart", seen, 1);

    // R3 watchdog prescaled 1:2
    wr_mode(6'h09); clr_wdt();
    ticks(2*WDT_STEPS - 1, seen);
    chk(!seen, "R3 wdt 1:2 no early", seen, 0);
    ticks(1, seen);
    chk(seen, "R3 wdt 1:2 timeout", seen, 1);

    // R9 clear also zeroes watchdog-owned prescaler
    ticks(1, seen);
    clr_wdt();
    ticks(2*WDT_STEPS - 1, seen);
    chk(!seen, "R9 prescaler cleared", seen, 0);
    ticks(1, seen);
    chk(seen, "R9 timeout after prescaler clear", seen, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule